// File: doc/BRIEF.md
# Host-to-FIFO Access Bridge (16-bit host, 18-bit FIFO words)

This block sits between a 16-bit host register bus and a bank of 18-bit-wide data FIFOs. It lets software fill the FIFOs and read them back. On a host data write, the block stores the 16 data bits and adds two tag bits, a last-word flag and an overlap flag. The tag values come from which of four write offsets was used. A select register sets which FIFOs take host writes. Several FIFOs can be selected together for a broadcast write.

While the select register is nonzero, the block owns the FIFO write side. When the select register is zero, the FIFO write port carries the live data-link path again, and host data writes are ignored.

Readback uses a one-hot choice of FIFO. An 18-bit word is returned in two halves: the 2 high bits and the 16 low bits. Only some read offsets advance the FIFO, so a word is read by fetching the high bits without advancing, then the low bits with an advance. A separate execute access advances the FIFO without returning data. The FIFO storage itself lives outside this block.

Top module: `fifo_host_bridge`

## Requirements
- R1: A host write at offset 0x00, 0x04, 0x08 or 0x0C drives `fifo_wdata` with the 16 data bits in [15:0]. Bit 16 is the last-word flag and equals address bit 2. Bit 17 is the overlap flag and equals address bit 3. So the offsets give tags 00, 01, 10 and 11 in (bit17, bit16) order.
- R2: While the select register is nonzero, each host data write raises `fifo_wen` and `fifo_wclk` for exactly one cycle. It does so on every selected FIFO that is not full, in the cycle after the access.
- R3: A host data write is dropped for any selected FIFO whose `fifo_full` is high, and it sets a sticky overflow flag. The flag reads back in bit 15 at offset 0x24 and clears only on a select-register write.
- R4: A host write at offset 0x20 loads the select register from `host_wdata[N_FIFO-1:0]`. A read at 0x24 returns those bits in the low positions, with zeros in the remaining bits below bit 15.
- R5: While the select register is zero, `fifo_wdata`, `fifo_wen` and `fifo_wclk` follow `link_wdata` and `link_wen` with one cycle of delay, and host data writes have no effect.
- R6: A read at 0x10 returns bits [15:0] of the head word of the FIFO picked by `rd_sel` and does not advance it. A read at 0x14 returns the same bits and pulses that FIFO's `fifo_ren`.
- R7: A read at 0x18 returns bits [17:16] of the head word in `host_rdata[1:0]`, with zeros above, and does not advance the FIFO. A read at 0x1C returns the same bits and advances the FIFO.
- R8: An execute access at 0x28 pulses `fifo_ren` of the picked FIFO and leaves `host_rdata` unchanged.
- R9: An advance request on an empty FIFO raises no `fifo_ren`. When `rd_sel` is not one-hot, data reads return zero and nothing advances.
- R10: After a synchronous reset, the select register, the overflow flag, `host_rdata`, `fifo_wen`, `fifo_wclk`, `fifo_ren` and `fifo_wdata` are zero.
- R11: A high-then-low read pair (0x18, then 0x14) returns one full word and advances the FIFO once, so the next pair returns the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Byte offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_ex | input | 1 | Host execute strobe, one cycle |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| link_wdata | input | 18 | Live data-link word |
| link_wen | input | N_FIFO | Live data-link write enables |
| fifo_wdata | output | 18 | Word presented to all FIFOs |
| fifo_wen | output | N_FIFO | Per-FIFO write enable |
| fifo_wclk | output | N_FIFO | Per-FIFO write clock pulse |
| fifo_full | input | N_FIFO | Per-FIFO full flag |
| rd_sel | input | N_FIFO | One-hot readback FIFO choice |
| fifo_rdata | input | N_FIFO*18 | Head word of each FIFO |
| fifo_empty | input | N_FIFO | Per-FIFO empty flag |
| fifo_ren | output | N_FIFO | Per-FIFO read advance pulse |

## Verification
The write path is driven with all four tag offsets, which separates the two flag bits and shows whether they are swapped. A broadcast to two FIFOs filled to capacity separates accepted writes from dropped ones, and shows whether the overflow flag is set and held. Reads mix advancing and non-advancing offsets, execute accesses, advances on an empty FIFO and rd_sel values that are not one-hot. The order of the returned values shows exactly which accesses moved the read pointer. Link-mode cycles with a competing host write show that the live path takes over and that host data writes are ignored.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
  localparam int WORD_W = 18;
  localparam int HOST_W = 16;
  localparam int TAG_W  = WORD_W - HOST_W;

  // Host offsets whose exact values are decoded by the block
  localparam logic [5:0] OFS_SEL_WR   = 6'h20;
  localparam logic [5:0] OFS_SEL_RD   = 6'h24;
  localparam logic [5:0] OFS_LO_PEEK  = 6'h10;
  localparam logic [5:0] OFS_LO_POP   = 6'h14;
  localparam logic [5:0] OFS_HI_PEEK  = 6'h18;
  localparam logic [5:0] OFS_HI_POP   = 6'h1C;
  localparam logic [5:0] OFS_ADVANCE  = 6'h28;
endpackage

// File: rtl/fhb_decode.sv
module fhb_decode
  import fhb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              ex,
  output logic              data_wr,
  output logic [TAG_W-1:0]  tag,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              rd_lo,
  output logic              rd_hi,
  output logic              adv,
  output logic              ex_adv
);
  logic in_data_window;

  always_comb begin
    in_data_window = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
    data_wr = wr && in_data_window;
    // overlap flag in the upper tag bit, last-word flag in the lower
    tag     = addr[3:2];
    sel_wr  = wr && (addr == ADDR_W'(OFS_SEL_WR));
    sel_rd  = rd && (addr == ADDR_W'(OFS_SEL_RD));
    rd_lo   = rd && ((addr == ADDR_W'(OFS_LO_PEEK)) || (addr == ADDR_W'(OFS_LO_POP)));
    rd_hi   = rd && ((addr == ADDR_W'(OFS_HI_PEEK)) || (addr == ADDR_W'(OFS_HI_POP)));
    ex_adv  = ex && (addr == ADDR_W'(OFS_ADVANCE));
    adv     = (rd && ((addr == ADDR_W'(OFS_LO_POP)) || (addr == ADDR_W'(OFS_HI_POP)))) || ex_adv;
  end
endmodule

// File: rtl/fhb_wr_path.sv
module fhb_wr_path
  import fhb_pkg::*;
#(
  parameter int N_FIFO = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [TAG_W-1:0]  tag,
  input  logic              sel_wr,
  input  logic [HOST_W-1:0] wdata,
  input  logic [WORD_W-1:0] link_wdata,
  input  logic [N_FIFO-1:0] link_wen,
  input  logic [N_FIFO-1:0] fifo_full,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic [N_FIFO-1:0] fifo_wen,
  output logic [N_FIFO-1:0] fifo_wclk,
  output logic [N_FIFO-1:0] sel_q,
  output logic              ovf_q
);
  logic              host_mode;
  logic [N_FIFO-1:0] lane_go;
  logic [N_FIFO-1:0] lane_drop;

  assign host_mode = (sel_q != '0);

  // per-lane gating of a host write against that FIFO's full flag
  for (genvar g = 0; g < N_FIFO; g++) begin : g_lane
    assign lane_go[g]   = data_wr && sel_q[g] && !fifo_full[g];
    assign lane_drop[g] = data_wr && sel_q[g] &&  fifo_full[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ovf_q <= 1'b0;
    end else if (sel_wr) begin
      sel_q <= wdata[N_FIFO-1:0];
      ovf_q <= 1'b0;
    end else if (lane_drop != '0) begin
      ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wdata <= '0;
      fifo_wen   <= '0;
      fifo_wclk  <= '0;
    end else if (host_mode) begin
      if (data_wr) fifo_wdata <= {tag, wdata};
      fifo_wen  <= lane_go;
      fifo_wclk <= lane_go;
    end else begin
      fifo_wdata <= link_wdata;
      fifo_wen   <= link_wen;
      fifo_wclk  <= link_wen;
    end
  end

  AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (rst)
    (host_mode && data_wr) |=> ((fifo_wen & $past(fifo_full)) == '0)); // R3
  AST_WEN_IN_SEL: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> ((fifo_wen & ~$past(sel_q)) == '0)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !sel_wr) |=> ovf_q); // R3
  AST_CLK_WITH_WEN: assert property (@(posedge clk) disable iff (rst)
    fifo_wclk == fifo_wen); // R2
endmodule

// File: rtl/fhb_rd_path.sv
module fhb_rd_path
  import fhb_pkg::*;
#(
  parameter int N_FIFO = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_lo,
  input  logic                     rd_hi,
  input  logic                     sel_rd,
  input  logic                     adv,
  input  logic                     ex_adv,
  input  logic [N_FIFO-1:0]        rd_sel,
  input  logic [N_FIFO*WORD_W-1:0] fifo_rdata,
  input  logic [N_FIFO-1:0]        fifo_empty,
  input  logic [N_FIFO-1:0]        sel_q,
  input  logic                     ovf_q,
  output logic [HOST_W-1:0]        host_rdata,
  output logic [N_FIFO-1:0]        fifo_ren
);
  logic [WORD_W-1:0] lane_word [N_FIFO];
  logic [WORD_W-1:0] picked;
  logic              pick_ok;
  logic [HOST_W-1:0] sel_word;

  for (genvar g = 0; g < N_FIFO; g++) begin : g_mux
    assign lane_word[g] = rd_sel[g] ? fifo_rdata[g*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_FIFO; i++) picked = picked | lane_word[i];
    pick_ok = (rd_sel != '0) && ((rd_sel & (rd_sel - 1'b1)) == '0);
    // overflow in the top bit, select bits at the bottom (N_FIFO < HOST_W)
    sel_word = '0;
    sel_word[N_FIFO-1:0] = sel_q;
    sel_word[HOST_W-1]   = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      fifo_ren   <= '0;
    end else begin
      if (rd_lo)
        host_rdata <= pick_ok ? picked[HOST_W-1:0] : '0;
      else if (rd_hi)
        host_rdata <= pick_ok ? {{(HOST_W-TAG_W){1'b0}}, picked[WORD_W-1:HOST_W]} : '0;
      else if (sel_rd)
        host_rdata <= sel_word;
      fifo_ren <= (adv && pick_ok) ? (rd_sel & ~fifo_empty) : '0;
    end
  end

  AST_REN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_ren)); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    adv |=> ((fifo_ren & $past(fifo_empty)) == '0)); // R9
  AST_EX_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    ex_adv |=> $stable(host_rdata)); // R8
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (rst)
    !adv |=> (fifo_ren == '0)); // R6
endmodule

// File: rtl/fifo_host_bridge.sv
module fifo_host_bridge
  import fhb_pkg::*;
#(
  parameter int N_FIFO = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic                     host_ex,
  input  logic [HOST_W-1:0]        host_wdata,
  output logic [HOST_W-1:0]        host_rdata,
  input  logic [WORD_W-1:0]        link_wdata,
  input  logic [N_FIFO-1:0]        link_wen,
  output logic [WORD_W-1:0]        fifo_wdata,
  output logic [N_FIFO-1:0]        fifo_wen,
  output logic [N_FIFO-1:0]        fifo_wclk,
  input  logic [N_FIFO-1:0]        fifo_full,
  input  logic [N_FIFO-1:0]        rd_sel,
  input  logic [N_FIFO*WORD_W-1:0] fifo_rdata,
  input  logic [N_FIFO-1:0]        fifo_empty,
  output logic [N_FIFO-1:0]        fifo_ren
);
  logic              d_data_wr, d_sel_wr, d_sel_rd, d_rd_lo, d_rd_hi, d_adv, d_ex_adv;
  logic [TAG_W-1:0]  d_tag;
  logic [N_FIFO-1:0] sel_q;
  logic              ovf_q;

  fhb_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(host_addr), .wr(host_wr), .rd(host_rd), .ex(host_ex),
    .data_wr(d_data_wr), .tag(d_tag), .sel_wr(d_sel_wr), .sel_rd(d_sel_rd),
    .rd_lo(d_rd_lo), .rd_hi(d_rd_hi), .adv(d_adv), .ex_adv(d_ex_adv)
  );

  fhb_wr_path #(.N_FIFO(N_FIFO)) wr_i (
    .clk(clk), .rst(rst), .data_wr(d_data_wr), .tag(d_tag), .sel_wr(d_sel_wr),
    .wdata(host_wdata), .link_wdata(link_wdata), .link_wen(link_wen),
    .fifo_full(fifo_full), .fifo_wdata(fifo_wdata), .fifo_wen(fifo_wen),
    .fifo_wclk(fifo_wclk), .sel_q(sel_q), .ovf_q(ovf_q)
  );

  fhb_rd_path #(.N_FIFO(N_FIFO)) rd_i (
    .clk(clk), .rst(rst), .rd_lo(d_rd_lo), .rd_hi(d_rd_hi), .sel_rd(d_sel_rd),
    .adv(d_adv), .ex_adv(d_ex_adv), .rd_sel(rd_sel), .fifo_rdata(fifo_rdata),
    .fifo_empty(fifo_empty), .sel_q(sel_q), .ovf_q(ovf_q),
    .host_rdata(host_rdata), .fifo_ren(fifo_ren)
  );

  AST_LINK_PASS: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |=> (fifo_wen == $past(link_wen))); // R5
  AST_DATA_TAG: assert property (@(posedge clk) disable iff (rst)
    ((sel_q != '0) && d_data_wr) |=> (fifo_wdata[WORD_W-1:HOST_W] == $past(host_addr[3:2]))); // R1
endmodule

// File: tb/fifo_host_bridge_tb.sv
module fifo_host_bridge_tb_top;
  localparam int N = 4;
  localparam int DEPTH = 4;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_ex = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [W-1:0] link_wdata = '0;
  logic [N-1:0] link_wen = '0;
  logic [W-1:0] fifo_wdata;
  logic [N-1:0] fifo_wen, fifo_wclk, fifo_full, fifo_empty, fifo_ren;
  logic [N-1:0] rd_sel = '0;
  logic [N*W-1:0] fifo_rdata;

  always #2.5 clk = ~clk;

  fifo_host_bridge #(.N_FIFO(N), .ADDR_W(6)) dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_ex(host_ex), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .link_wdata(link_wdata), .link_wen(link_wen), .fifo_wdata(fifo_wdata),
    .fifo_wen(fifo_wen), .fifo_wclk(fifo_wclk), .fifo_full(fifo_full),
    .rd_sel(rd_sel), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_ren(fifo_ren)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural FIFO bank
  logic [W-1:0] mem [N][DEPTH];
  int cnt [N];
  int rp [N];
  int wp [N];

  for (genvar g = 0; g < N; g++) begin : g_model
    assign fifo_full[g]  = (cnt[g] == DEPTH);
    assign fifo_empty[g] = (cnt[g] == 0);
    assign fifo_rdata[g*W +: W] = mem[g][rp[g]];
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        cnt[i] <= 0; rp[i] <= 0; wp[i] <= 0;
        for (int k = 0; k < DEPTH; k++) mem[i][k] <= '0;
      end else begin
        int c;
        c = cnt[i];
        if (fifo_ren[i]) begin
          if (c == 0) begin
            bad++; total++;
            $display("FAIL R9 advance on empty fifo %0d: act=ren exp=none", i);
          end else begin
            rp[i] <= (rp[i] + 1) % DEPTH; c = c - 1;
          end
        end
        if (fifo_wen[i]) begin
          if (cnt[i] == DEPTH) begin
            bad++; total++;
            $display("FAIL R3 write into full fifo %0d: act=wen exp=drop", i);
          end else begin
            mem[i][wp[i]] <= fifo_wdata; wp[i] <= (wp[i] + 1) % DEPTH; c = c + 1;
          end
        end
        cnt[i] <= c;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_X = 2'd2;
  // {op, addr, rd_sel, wdata, expected}; for writes expected is the fifo_wen mask
  localparam int NV = 23;
  localparam logic [43:0] VECS [NV] = '{
    {OP_W, 6'h20, 4'h0, 16'h0003, 16'h0000}, // R4 select fifo0+fifo1
    {OP_W, 6'h00, 4'h0, 16'h1234, 16'h0003}, // R1 R2 no flags, broadcast
    {OP_W, 6'h04, 4'h0, 16'hABCD, 16'h0003}, // R1 last-word
    {OP_W, 6'h08, 4'h0, 16'h0F0F, 16'h0003}, // R1 overlap
    {OP_W, 6'h0C, 4'h0, 16'hFFFF, 16'h0003}, // R1 both flags, now full
    {OP_W, 6'h00, 4'h0, 16'h5555, 16'h0000}, // R3 dropped on full
    {OP_R, 6'h24, 4'h0, 16'h0000, 16'h8003}, // R3 R4 overflow + select readback
    {OP_W, 6'h20, 4'h0, 16'h0000, 16'h0000}, // R4 R5 back to link path
    {OP_R, 6'h24, 4'h0, 16'h0000, 16'h0000}, // R3 cleared by select write
    {OP_R, 6'h18, 4'h1, 16'h0000, 16'h0000}, // R11 high part first
    {OP_R, 6'h14, 4'h1, 16'h0000, 16'h1234}, // R11 R6 low part with advance
    {OP_R, 6'h18, 4'h1, 16'h0000, 16'h0001}, // R7 R11 next word high
    {OP_R, 6'h10, 4'h1, 16'h0000, 16'hABCD}, // R6 peek low
    {OP_R, 6'h10, 4'h1, 16'h0000, 16'hABCD}, // R6 peek did not advance
    {OP_R, 6'h1C, 4'h1, 16'h0000, 16'h0001}, // R7 high with advance
    {OP_X, 6'h28, 4'h1, 16'h0000, 16'h0001}, // R8 execute advance, data held
    {OP_R, 6'h18, 4'h1, 16'h0000, 16'h0003}, // R8 skipped 0x20F0F
    {OP_R, 6'h14, 4'h1, 16'h0000, 16'hFFFF}, // R6 last word, fifo0 empty
    {OP_X, 6'h28, 4'h1, 16'h0000, 16'hFFFF}, // R9 advance on empty
    {OP_R, 6'h10, 4'h2, 16'h0000, 16'h1234}, // R6 fifo1 untouched
    {OP_R, 6'h10, 4'h3, 16'h0000, 16'h0000}, // R9 not one-hot reads zero
    {OP_R, 6'h14, 4'h3, 16'h0000, 16'h0000}, // R9 not one-hot, no advance
    {OP_R, 6'h10, 4'h2, 16'h0000, 16'h1234}  // R9 fifo1 head still first word
  };

  task automatic run_vec(input logic [43:0] v);
    logic [1:0] op;
    logic [5:0] a;
    logic [15:0] wd, ex;
    bit is_data;
    op = v[43:42]; a = v[41:36]; wd = v[31:16]; ex = v[15:0];
    is_data = (a[5:4] == 2'b00) && (a[1:0] == 2'b00);
    @(negedge clk);
    host_addr = a; host_wdata = wd; rd_sel = v[35:32];
    host_wr = (op == OP_W); host_rd = (op == OP_R); host_ex = (op == OP_X);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_ex = 1'b0;
    if (op == OP_W) begin
      chk(fifo_wen == ex[N-1:0], "R2 wen mask", 32'(fifo_wen), 32'(ex[N-1:0]));
      chk(fifo_wclk == ex[N-1:0], "R2 wclk mask", 32'(fifo_wclk), 32'(ex[N-1:0]));
      if (is_data && ex != 0)
        chk(fifo_wdata == {a[3], a[2], wd}, "R1 tagged word", 32'(fifo_wdata), 32'({a[3], a[2], wd}));
    end else begin
      chk(host_rdata == ex, (op == OP_X) ? "R8 rdata held" : "R6/R7 readback",
          32'(host_rdata), 32'(ex));
    end
    @(negedge clk);
    if (op == OP_W)
      chk(fifo_wen == '0, "R2 single-cycle pulse", 32'(fifo_wen), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(host_rdata == '0, "R10 rdata reset", 32'(host_rdata), 32'h0);
    chk(fifo_wen == '0 && fifo_wclk == '0, "R10 wen reset", 32'(fifo_wen), 32'h0);
    chk(fifo_ren == '0, "R10 ren reset", 32'(fifo_ren), 32'h0);
    chk(fifo_wdata == '0, "R10 wdata reset", 32'(fifo_wdata), 32'h0);
    run_vec({OP_R, 6'h24, 4'h0, 16'h0000, 16'h0000}); // R10 select and overflow clear

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R5: link path drives the FIFO write side while select is zero
    @(negedge clk);
    link_wdata = 18'h2AAAA; link_wen = 4'b0100;
    @(negedge clk);
    link_wen = '0;
    chk(fifo_wdata == 18'h2AAAA, "R5 link data", 32'(fifo_wdata), 32'h2AAAA);
    chk(fifo_wen == 4'b0100, "R5 link wen", 32'(fifo_wen), 32'h4);
    chk(fifo_wclk == 4'b0100, "R5 link wclk", 32'(fifo_wclk), 32'h4);

    // R5: host data write in link mode has no effect
    link_wdata = 18'h00005;
    host_addr = 6'h04; host_wdata = 16'h1111; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk(fifo_wen == '0, "R5 host write ignored wen", 32'(fifo_wen), 32'h0);
    chk(fifo_wdata == 18'h00005, "R5 host write ignored data", 32'(fifo_wdata), 32'h5);

    // R9: fifo0 still consistent after the advance on empty
    run_vec({OP_W, 6'h20, 4'h0, 16'h0001, 16'h0000});
    run_vec({OP_W, 6'h00, 4'h0, 16'h0077, 16'h0001});
    run_vec({OP_W, 6'h20, 4'h0, 16'h0000, 16'h0000});
    run_vec({OP_R, 6'h10, 4'h1, 16'h0000, 16'h0077}); // R9

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule